// File: doc/BRIEF.md
# Serial EEPROM Station-Address Reader

This block pulls a short run of bytes, such as a six-byte network station address, out of a two-wire serial EEPROM. It does the whole random-read transaction without help. It opens the bus with a start condition, sends the write control byte `0xA0` and then the byte address. It then issues a repeated start and the read control byte `0xA1`, and clocks in the data bytes. The transaction closes with a stop condition. The host only pulses a start input and picks one of four preset start offsets with a 2-bit select.

The clock pin is a plain level output. The data pin is split into a drive-enable, a drive value and a sensed level, so that it can be wired as an open-drain pad. Each bit slot lasts four quarter phases, and each quarter lasts `QDIV` system clocks. The clock pin is high during the middle two quarters of every slot. The controller checks for an acknowledge after each byte it sends. A missing acknowledge makes it send a stop, report an error and go back to idle.

Received bytes leave on `data_o` with a one-cycle `valid_o` strobe. This is a push-only stream with no ready input. The consumer must take each byte in the cycle it is strobed. The byte stays on `data_o` until the next byte arrives. Completion is marked by a one-cycle `done_o` pulse. `err_o` then tells whether the transfer was aborted.

Top module: `eeprom_addr_reader`

## Requirements
- R1: After reset the block is idle. `busy_o`, `valid_o`, `done_o`, `err_o`, `scl_o` and `sda_en_o` are all low.
- R2: The driven data level changes while the clock pin is high only in two cases: a high-to-low change with the driver on (start), and a low-to-high change (stop). Every other data change happens while the clock is low.
- R3: One transfer is: start, `0xA0`, byte address, repeated start (no stop in between), `0xA1`, the data bytes, stop. The EEPROM therefore sees exactly two start conditions and one stop.
- R4: `offset_sel_i` is sampled when a start is accepted. Value 0 selects byte address 0x83, 1 selects 0x99, 2 selects 0xAF and 3 selects 0xF8.
- R5: Every bit slot is `4*QDIV` clocks long, and the clock pin stays high for exactly `2*QDIV` consecutive clocks in each slot. Bytes move most significant bit first, in both directions.
- R6: After each byte it sends, the controller releases the data driver for one slot and samples the line while the clock is high. A low level counts as acknowledge.
- R7: After each received byte except the last, the controller drives data low for one slot (acknowledge). After the sixth byte it drives data high (no acknowledge) and then sends stop.
- R8: If an acknowledge is missing, the controller sends stop right away, receives no data bytes, and finishes with `err_o` high. `err_o` stays high until the next accepted start clears it.
- R9: Each received byte appears on `data_o` with `valid_o` high for exactly one cycle. A successful transfer gives exactly six strobes, and byte `i` equals the EEPROM content at offset + `i` (modulo 256).
- R10: `busy_o` is high from the cycle after a start is accepted until the stop finishes. `done_o` then pulses for exactly one cycle, with `busy_o` already low.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The transfer in progress keeps its offset and produces a single `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer; honoured only when idle |
| offset_sel_i | input | 2 | Selects one of four preset start offsets |
| sda_i | input | 1 | Sensed level of the serial data line |
| scl_o | output | 1 | Serial clock level |
| sda_en_o | output | 1 | Data driver enable (1 = controller drives the line) |
| sda_o | output | 1 | Level driven on the data line when enabled |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer, successful or aborted, has finished |
| err_o | output | 1 | The last transfer was aborted by a missing acknowledge |
| data_o | output | 8 | Most recent received byte |
| valid_o | output | 1 | One-cycle strobe marking a new byte on `data_o` |

## Verification
Some rules are checked by assertions on every clock. These are: the data level stays steady while the clock is high outside start and stop, and a falling or rising data edge under a high clock belongs to the start or stop phase. The driver is released in every acknowledge-sampling and receive slot, and the acknowledge or no-acknowledge level is driven after each received byte. The strobes for valid and done are single-cycle, and the offset is frozen while busy. Other properties only show up against the bench's behavioural EEPROM. These are the exact byte order on the wire, the address the EEPROM decodes, the data returned for each of the four offsets, and the count of starts and stops. The bench also sweeps an injected missing acknowledge across the three sent bytes for every offset to show the abort path, the sticky error, and that a start pulse mid-transfer is ignored.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  // Phases of the serial transaction; each phase spans whole bit slots.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_TX,
    PH_TXACK,
    PH_RX,
    PH_MACK,
    PH_STOP
  } phase_e;

  // Which byte of the addressing preamble is being sent.
  typedef enum logic [1:0] {
    ST_CTRL_WR,
    ST_WORD_ADDR,
    ST_CTRL_RD
  } step_e;

  localparam logic [7:0] CTRL_WRITE = 8'hA0;
  localparam logic [7:0] CTRL_READ  = 8'hA1;

  // Levels presented on the serial pins.
  typedef struct packed {
    logic scl;
    logic sda_en;
    logic sda;
  } pins_t;
endpackage

// File: rtl/eeprom_qtick.sv
// Quarter-phase timer: tick every QDIV clocks while run is high.
module eeprom_qtick #(
  parameter int QDIV = 4,
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       tick,
  output logic [1:0] quarter
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QDIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (!run) begin
      cnt     <= '0;
      quarter <= 2'd0;
    end else if (tick) begin
      cnt     <= '0;
      quarter <= quarter + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R5: quarters advance one step per tick, slot after slot
  assert_quarter_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> quarter == $past(quarter) + 2'd1);
endmodule

// File: rtl/eeprom_offset_lut.sv
// Maps the select input to one of NSEL preset byte offsets.
module eeprom_offset_lut #(
  parameter int NSEL = 4,
  parameter int AW   = 8,
  parameter logic [NSEL*AW-1:0] TABLE = {8'hF8, 8'hAF, 8'h99, 8'h83},
  localparam int SW = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic [SW-1:0] sel,
  output logic [AW-1:0] offset
);
  logic [AW-1:0] entry [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_entry
    assign entry[i] = TABLE[i*AW +: AW];
  end

  assign offset = entry[sel];
endmodule

// File: rtl/eeprom_shreg.sv
// Shared shift register: MSB leaves first, new bits enter at the LSB.
module eeprom_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/eeprom_pin_gen.sv
// Pin levels as a function of phase and quarter. The clock is high in
// quarters 1 and 2 of every slot; data moves only in quarter 0 except
// for the start (falls in q2) and stop (rises in q2).
module eeprom_pin_gen
  import eeprom_rd_pkg::*;
(
  input  phase_e     phase,
  input  logic [1:0] quarter,
  input  logic       tx_bit,
  input  logic       last_byte,
  output pins_t      pins
);
  always_comb begin
    pins.scl    = (phase != PH_IDLE) && (quarter == 2'd1 || quarter == 2'd2);
    pins.sda_en = 1'b0;
    pins.sda    = 1'b1;
    unique case (phase)
      PH_START: begin
        pins.sda_en = 1'b1;
        pins.sda    = ~quarter[1];
      end
      PH_STOP: begin
        pins.sda_en = (quarter != 2'd3);
        pins.sda    = quarter[1];
      end
      PH_TX: begin
        pins.sda_en = 1'b1;
        pins.sda    = tx_bit;
      end
      PH_MACK: begin
        pins.sda_en = 1'b1;
        pins.sda    = last_byte;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eeprom_addr_reader.sv
module eeprom_addr_reader
  import eeprom_rd_pkg::*;
#(
  parameter int QDIV   = 4,
  parameter int NBYTES = 6,
  parameter int NSEL   = 4,
  localparam int SW = (NSEL > 1) ? $clog2(NSEL) : 1,
  localparam int BW = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [SW-1:0] offset_sel_i,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_en_o,
  output logic          sda_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    data_o,
  output logic          valid_o
);
  phase_e          phase;
  step_e           step;
  logic [2:0]      bitn;
  logic [BW-1:0]   rx_idx;
  logic            nack_seen;
  logic            abort;
  logic            err_q;
  logic            done_q;
  logic            valid_q;
  logic [7:0]      data_q;
  logic [7:0]      offset_q;
  logic [7:0]      lut_off;

  logic            tick;
  logic [1:0]      quarter;
  logic            samp;
  logic            slot_end;
  logic            last_byte;

  logic            sh_load;
  logic [7:0]      sh_val;
  logic            sh_shift;
  logic            sh_din;
  logic [7:0]      shq;
  pins_t           pins;

  assign samp      = tick && (quarter == 2'd1);
  assign slot_end  = tick && (quarter == 2'd3);
  assign last_byte = (rx_idx == BW'(NBYTES - 1));

  eeprom_qtick #(.QDIV(QDIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase != PH_IDLE),
    .tick    (tick),
    .quarter (quarter)
  );

  eeprom_offset_lut #(.NSEL(NSEL), .AW(8)) u_lut (
    .sel    (offset_sel_i),
    .offset (lut_off)
  );

  always_comb begin
    sh_load  = 1'b0;
    sh_val   = offset_q;
    sh_shift = 1'b0;
    sh_din   = 1'b0;
    if (phase == PH_START && slot_end) begin
      sh_load = 1'b1;
      sh_val  = (step == ST_CTRL_WR) ? CTRL_WRITE : CTRL_READ;
    end else if (phase == PH_TXACK && slot_end && step == ST_CTRL_WR) begin
      sh_load = 1'b1;
      sh_val  = offset_q;
    end
    if (phase == PH_TX && slot_end) sh_shift = 1'b1;
    if (phase == PH_RX && samp) begin
      sh_shift = 1'b1;
      sh_din   = sda_i;
    end
  end

  eeprom_shreg #(.W(8)) u_sh (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .din      (sh_din),
    .q        (shq)
  );

  eeprom_pin_gen u_pins (
    .phase     (phase),
    .quarter   (quarter),
    .tx_bit    (shq[7]),
    .last_byte (last_byte),
    .pins      (pins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      step      <= ST_CTRL_WR;
      bitn      <= 3'd0;
      rx_idx    <= '0;
      nack_seen <= 1'b0;
      abort     <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= 8'h00;
      offset_q  <= 8'h00;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start_i) begin
          phase    <= PH_START;
          step     <= ST_CTRL_WR;
          rx_idx   <= '0;
          abort    <= 1'b0;
          err_q    <= 1'b0;
          offset_q <= lut_off;
        end
        PH_START: if (slot_end) begin
          phase <= PH_TX;
          bitn  <= 3'd7;
        end
        PH_TX: if (slot_end) begin
          if (bitn == 3'd0) phase <= PH_TXACK;
          else              bitn  <= bitn - 3'd1;
        end
        PH_TXACK: begin
          if (samp) nack_seen <= sda_i;
          if (slot_end) begin
            if (nack_seen) begin
              abort <= 1'b1;
              phase <= PH_STOP;
            end else begin
              unique case (step)
                ST_CTRL_WR: begin
                  step  <= ST_WORD_ADDR;
                  phase <= PH_TX;
                  bitn  <= 3'd7;
                end
                ST_WORD_ADDR: begin
                  step  <= ST_CTRL_RD;
                  phase <= PH_START;
                end
                default: begin
                  phase <= PH_RX;
                  bitn  <= 3'd7;
                end
              endcase
            end
          end
        end
        PH_RX: if (slot_end) begin
          if (bitn == 3'd0) begin
            phase   <= PH_MACK;
            valid_q <= 1'b1;
            data_q  <= shq;
          end else begin
            bitn <= bitn - 3'd1;
          end
        end
        PH_MACK: if (slot_end) begin
          if (last_byte) begin
            phase <= PH_STOP;
          end else begin
            rx_idx <= rx_idx + BW'(1);
            phase  <= PH_RX;
            bitn   <= 3'd7;
          end
        end
        PH_STOP: if (slot_end) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
          err_q  <= abort;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign scl_o    = pins.scl;
  assign sda_en_o = pins.sda_en;
  assign sda_o    = pins.sda;
  assign busy_o   = (phase != PH_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign data_o   = data_q;
  assign valid_o  = valid_q;

  // R1: an idle controller leaves both pins alone
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sda_en_o && !scl_o);

  // R2: data steady under a high clock outside start/stop
  assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && phase != PH_START && phase != PH_STOP)
      |-> $stable(sda_en_o) && $stable(sda_o));

  // R2: a falling data edge under a high clock is a driven start
  assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_o) && scl_o) |-> (phase == PH_START) && sda_en_o);

  // R2: a rising data edge under a high clock is a stop
  assert_stop_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_o) && scl_o) |-> phase == PH_STOP);

  // R6: driver released while the EEPROM owns the line
  assert_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TXACK || phase == PH_RX) |-> !sda_en_o);

  // R7: acknowledge low after early bytes, high after the final one
  assert_mack_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MACK) |-> sda_en_o && (sda_o == last_byte));

  // R8: an error is only raised as the transfer finishes
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  // R9: a strobe lasts one cycle and coincides with the acknowledge slot
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> phase == PH_MACK);

  // R10: done is a single pulse seen after busy has dropped
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R11: the chosen offset cannot change during a transfer
  assert_offset_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(offset_q));
endmodule

// File: tb/sim_eeprom_addr_reader.sv
`timescale 1ns/1ps
module sim_eeprom_addr_reader;
  localparam int QDIV   = 2;
  localparam int NBYTES = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       start_i;
  logic [1:0] offset_sel_i;
  logic       scl_o, sda_en_o, sda_o, busy_o, done_o, err_o, valid_o;
  logic [7:0] data_o;
  logic       s_low = 1'b0;
  logic       sda_line;

  assign sda_line = (sda_en_o ? sda_o : 1'b1) & ~s_low;

  eeprom_addr_reader #(.QDIV(QDIV), .NBYTES(NBYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_sel_i(offset_sel_i),
    .sda_i(sda_line), .scl_o(scl_o), .sda_en_o(sda_en_o), .sda_o(sda_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .data_o(data_o),
    .valid_o(valid_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [7:0] mem_byte(input logic [7:0] a);
    logic [7:0] m;
    m = a * 8'd29;
    return m ^ 8'hC3;
  endfunction

  function automatic logic [7:0] exp_off(input int s);
    case (s)
      0: return 8'h83;
      1: return 8'h99;
      2: return 8'hAF;
      default: return 8'hF8;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM ----------------
  localparam int M_IDLE = 0, M_RECV = 1, M_ACK = 2, M_SEND = 3, M_MWAIT = 4;
  int         md = M_IDLE;
  int         bcnt = 0, bno = 0, gbyte = 0, nack_at = -1;
  int         starts = 0, stops = 0, m_acks = 0, m_nacks = 0;
  logic [7:0] sh = 8'h00, addr_ptr = 8'h00;
  logic [7:0] rx_log [3];
  logic       rd = 1'b0, mack = 1'b0, p_scl = 1'b0, p_sda = 1'b1;

  always @(negedge clk) begin
    logic l_scl, l_sda;
    l_scl = scl_o;
    l_sda = sda_line;
    if (l_scl && p_scl && p_sda && !l_sda) begin
      md = M_RECV; bcnt = 0; bno = 0; s_low = 1'b0; starts++;
    end else if (l_scl && p_scl && !p_sda && l_sda) begin
      md = M_IDLE; s_low = 1'b0; stops++;
    end else if (l_scl && !p_scl) begin
      if (md == M_RECV) begin sh = {sh[6:0], l_sda}; bcnt++; end
      else if (md == M_MWAIT) mack = l_sda;
    end else if (!l_scl && p_scl) begin
      case (md)
        M_RECV: if (bcnt == 8) begin
          if (gbyte < 3) rx_log[gbyte] = sh;
          if (gbyte == nack_at) md = M_IDLE;
          else begin
            if (bno == 0) rd = (sh == 8'hA1);
            else addr_ptr = sh;
            s_low = 1'b1;
            md = M_ACK;
          end
          gbyte++; bno++;
        end
        M_ACK: begin
          if (rd) begin
            sh = mem_byte(addr_ptr); bcnt = 0; s_low = ~sh[7]; md = M_SEND;
          end else begin
            s_low = 1'b0; bcnt = 0; md = M_RECV;
          end
        end
        M_SEND: begin
          bcnt++;
          if (bcnt == 8) begin s_low = 1'b0; md = M_MWAIT; end
          else s_low = ~sh[7-bcnt];
        end
        M_MWAIT: begin
          if (!mack) begin
            m_acks++; addr_ptr = addr_ptr + 8'd1;
            sh = mem_byte(addr_ptr); bcnt = 0; s_low = ~sh[7]; md = M_SEND;
          end else begin
            m_nacks++; md = M_IDLE;
          end
        end
        default: ;
      endcase
    end
    p_scl = l_scl;
    p_sda = l_sda;
  end

  // ---------------- transfer driver ----------------
  logic [7:0] got [8];
  int  n_got, dbl, hi_bad, done_seen, extra_done;
  logic done_err, busy_at_start, err_at_start;

  task automatic run_xfer(input int sel, input int nk, input bit poke);
    int cyc, hirun;
    logic prev_v;
    md = M_IDLE; gbyte = 0; nack_at = nk; starts = 0; stops = 0;
    m_acks = 0; m_nacks = 0; rd = 1'b0;
    n_got = 0; dbl = 0; hi_bad = 0; done_seen = 0; extra_done = 0;
    hirun = 0; prev_v = 1'b0; done_err = 1'b0;
    @(negedge clk);
    offset_sel_i = 2'(sel);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy_at_start = busy_o;
    err_at_start  = err_o;
    cyc = 0;
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 60) begin start_i = 1'b1; offset_sel_i = 2'(sel ^ 1); end
      else if (poke && cyc == 61) start_i = 1'b0;
      if (valid_o) begin
        if (n_got < 8) got[n_got] = data_o;
        n_got++;
        if (prev_v) dbl++;
      end
      prev_v = valid_o;
      if (scl_o) hirun++;
      else begin
        if (hirun != 0 && hirun != 2 * QDIV) hi_bad++;
        hirun = 0;
      end
      if (done_o) begin done_seen++; done_err = err_o; break; end
    end
    repeat (3 * 4 * QDIV) begin
      @(negedge clk);
      if (done_o) extra_done++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; offset_sel_i = 2'd0;
    repeat (5) @(negedge clk);
    chk("R1", "outputs in reset", {busy_o, valid_o, done_o, err_o, scl_o, sda_en_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "outputs after reset", {busy_o, valid_o, done_o, err_o, scl_o, sda_en_o}, 0);

    // successful reads at every offset
    for (int s = 0; s < 4; s++) begin
      run_xfer(s, -1, 1'b0);
      chk("R10", "busy after start", busy_at_start, 1);
      chk("R10", "single done", done_seen + extra_done, 1);
      chk("R8", "no error on good read", done_err, 0);
      chk("R3", "write control byte", rx_log[0], 8'hA0);
      chk("R4", "decoded address", rx_log[1], exp_off(s));
      chk("R3", "read control byte", rx_log[2], 8'hA1);
      chk("R3", "start conditions", starts, 2);
      chk("R3", "stop conditions", stops, 1);
      chk("R7", "acks from master", m_acks, NBYTES - 1);
      chk("R7", "final no-ack", m_nacks, 1);
      chk("R9", "strobe count", n_got, NBYTES);
      chk("R9", "back-to-back strobes", dbl, 0);
      chk("R5", "clock high width violations", hi_bad, 0);
      for (int i = 0; i < NBYTES; i++)
        chk("R9", "data byte", got[i], mem_byte(8'(exp_off(s) + i)));
      chk("R10", "idle after done", busy_o, 0);
    end

    // missing acknowledge on each sent byte, every offset
    for (int s = 0; s < 4; s++) begin
      for (int nk = 0; nk < 3; nk++) begin
        run_xfer(s, nk, 1'b0);
        chk("R8", "error flagged", done_err, 1);
        chk("R8", "no data after abort", n_got, 0);
        chk("R8", "stop after abort", stops, 1);
        chk("R6", "bytes sent before abort", gbyte, nk + 1);
        chk("R8", "error held while idle", err_o, 1);
        chk("R10", "single done on abort", done_seen + extra_done, 1);
      end
      run_xfer(s, -1, 1'b0);
      chk("R8", "error cleared by new start", err_at_start, 0);
      chk("R8", "recovered read", (n_got == NBYTES) && !done_err, 1);
    end

    // start pulse while busy must be ignored
    run_xfer(1, -1, 1'b1);
    chk("R11", "one done despite extra start", done_seen + extra_done, 1);
    chk("R11", "offset kept", rx_log[1], exp_off(1));
    chk("R11", "byte count", n_got, NBYTES);
    for (int i = 0; i < NBYTES; i++)
      chk("R11", "data from original offset", got[i], mem_byte(8'(exp_off(1) + i)));
    chk("R11", "no second transfer", busy_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule